// File: doc/BRIEF.md
# Phase-Shifted Multi-Channel PWM Generator

This block drives six switch channels (five load outputs and one external-switch control) from one shared period counter of 128 steps. Each channel has a 10-bit control word with three fields: an enable bit, a 7-bit duty code and a 2-bit phase code. The duty code N gives an on-time of (N+1)/128 of the period. The all-ones code holds the output on with no PWM. The phase code moves the start of the on-window by whole quarter periods, so channels that share a supply do not all switch at the same instant.

The counter advances only when the `tick` input is high, so an external prescaler sets the PWM frequency. Control words come in continuously from a register file. Each channel copies its word into an active copy only when the counter wraps. A duty or phase change therefore never cuts a period short and never stretches one. Drive outputs come from flops and line up with the counter value they decode.

Top module: `pwm_phase_gen`

## Requirements
- R1: The period counter resets to 0. It advances by one on each clock with `tick` high, wraps from 127 to 0, and holds when `tick` is low.
- R2: A channel whose active word has bit 7 (enable) at 0 holds its drive low, whatever its duty and phase bits.
- R3: With enable 1, phase 00 and duty code N in bits 6:0, the drive is high exactly while the counter value is at most N. That is N+1 of every 128 ticks: code 0x00 gives 1 tick and 0x1A gives 27 ticks.
- R4: With enable 1 and duty code 0x7F, the drive is high on every cycle.
- R5: Phase code P in bits 9:8 (00, 01, 10, 11 for 0, 90, 180, 270 degrees) moves the window start to counter value 32*P. The drive is high when (counter − 32*P) mod 128 ≤ N.
- R6: A channel samples its control word only on the tick that wraps the counter from 127 to 0, and the new value governs from counter value 0. A word that changes at any other time has no effect on the drive until that wrap.
- R7: While reset is low, and after it until the first wrap, every active word is cleared and every drive is low.
- R8: Channel k takes its word from `ctrl_words[10k+9:10k]`. All six channels decode the same format and act independently of each other.
- R9: The drive outputs change only on a clock edge where `tick` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance enable from the prescaler |
| ctrl_words | input | 60 | Six packed control words, channel 0 in the low bits |
| drive | output | 6 | Channel drive outputs, bit k for channel k |

## Verification
The assertions assume that `tick` and `ctrl_words` are always known values that change only between clock edges. They assume nothing about when words change relative to the period boundary, so a word may move at any cycle, including the wrap cycle itself. The stimulus drives every input at the falling edge. It changes words at random points in mid-period and on wrap cycles, and it runs both an unbroken `tick` and a sparse random one. All window and hold properties are therefore exercised away from the boundary as well as at it.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;

  // Phase field of a control word: window start in quarter periods.
  typedef enum logic [1:0] {
    PH_DEG0   = 2'd0,
    PH_DEG90  = 2'd1,
    PH_DEG180 = 2'd2,
    PH_DEG270 = 2'd3
  } phase_e;

  localparam int PHASE_W     = 2;
  localparam int CNT_W_DFLT  = 7;
  localparam int NUM_CH_DFLT = 6;

endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             period_wrap
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Period boundary: the tick that carries the counter from top back to zero.
  assign period_wrap = tick && (cnt_q == CNT_MAX);

  always_comb begin
    if (!tick)
      cnt_nxt = cnt_q;
    else if (period_wrap)
      cnt_nxt = '0;
    else
      cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_phase_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int WORD_W = CNT_W + 1 + PHASE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic [CNT_W-1:0]  cnt_nxt,
  output logic [WORD_W-1:0] act_word,
  output logic              drive
);

  localparam int EN_BIT = CNT_W;
  localparam int PH_LSB = CNT_W + 1;

  logic [WORD_W-1:0] word_nxt;
  logic              drive_nxt;

  // Counter position relative to this channel's window start.
  function automatic logic [CNT_W-1:0] rel_pos(input logic [CNT_W-1:0] c,
                                               input phase_e ph);
    logic [CNT_W-1:0] offset;
    offset = {ph, {(CNT_W-PHASE_W){1'b0}}};
    return c - offset;
  endfunction

  // Window decode: positions 0..duty are on, so duty N covers N+1 steps.
  function automatic logic in_window(input logic [WORD_W-1:0] w,
                                     input logic [CNT_W-1:0] c);
    phase_e           ph;
    logic [CNT_W-1:0] duty;
    ph   = phase_e'(w[PH_LSB +: PHASE_W]);
    duty = w[CNT_W-1:0];
    return w[EN_BIT] && (rel_pos(c, ph) <= duty);
  endfunction

  assign word_nxt  = load ? word_in : act_word;
  assign drive_nxt = in_window(word_nxt, cnt_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_word <= '0;
      drive    <= 1'b0;
    end else begin
      act_word <= word_nxt;
      drive    <= drive_nxt;
    end
  end

endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
  import pwm_phase_pkg::*;
#(
  parameter int NUM_CH = NUM_CH_DFLT,
  parameter int CNT_W  = CNT_W_DFLT,
  localparam int WORD_W = CNT_W + 1 + PHASE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic [NUM_CH*WORD_W-1:0] ctrl_words,
  output logic [NUM_CH-1:0]        drive
);

  logic [CNT_W-1:0]         cnt_q;
  logic [CNT_W-1:0]         cnt_nxt;
  logic                     period_wrap;
  logic [NUM_CH*WORD_W-1:0] act_words;

  pwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .cnt_q       (cnt_q),
    .cnt_nxt     (cnt_nxt),
    .period_wrap (period_wrap)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    pwm_chan #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (period_wrap),
      .word_in  (ctrl_words[k*WORD_W +: WORD_W]),
      .cnt_nxt  (cnt_nxt),
      .act_word (act_words[k*WORD_W +: WORD_W]),
      .drive    (drive[k])
    );
  end

endmodule

// File: rtl/pwm_phase_chk.sv
module pwm_phase_chk #(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 7,
  localparam int WORD_W = CNT_W + 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick,
  input logic [CNT_W-1:0]         cnt,
  input logic                     wrap,
  input logic [NUM_CH*WORD_W-1:0] ctrl_words,
  input logic [NUM_CH*WORD_W-1:0] act_words,
  input logic [NUM_CH-1:0]        drive
);

  logic [NUM_CH-1:0] en_mask;
  logic [NUM_CH-1:0] full_mask;

  always_comb begin
    for (int k = 0; k < NUM_CH; k++) begin
      en_mask[k]   = act_words[k*WORD_W + CNT_W];
      full_mask[k] = &act_words[k*WORD_W +: CNT_W];
    end
  end

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> (cnt == $past(cnt) + 1'b1));

  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  // R2
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive & ~en_mask) == '0);

  // R4
  full_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_mask & full_mask) & ~drive) == '0);

  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_words));

  // R6
  word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (act_words == $past(ctrl_words)));

  // R9
  drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(drive));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_win
    // R5
    win_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_words[k*WORD_W + CNT_W] &&
       cnt == {act_words[k*WORD_W + CNT_W + 1 +: 2], {(CNT_W-2){1'b0}}})
      |-> drive[k]);
  end

endmodule

bind pwm_phase_gen pwm_phase_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .cnt        (cnt_q),
  .wrap       (period_wrap),
  .ctrl_words (ctrl_words),
  .act_words  (act_words),
  .drive      (drive)
);

// File: tb/sim_pwm_phase_gen.sv
module sim_pwm_phase_gen;

  localparam int NCH = 6;
  localparam int WW  = 10;
  localparam int PER = 128;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic [NCH*WW-1:0] ctrl_words = '0;
  logic [NCH-1:0]    drive;
  logic [NCH-1:0]    prev_drive;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Reference state: counter position and the words each channel is using.
  int m_cnt = 0;
  int m_act [NCH];
  int hi_cnt [NCH];

  always #4 clk = ~clk;

  pwm_phase_gen u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .ctrl_words (ctrl_words),
    .drive      (drive)
  );

  function automatic int mkw(int ph, int en, int duty);
    return (ph << 8) | (en << 7) | duty;
  endfunction

  function automatic bit expect_on(int w, int c);
    int en, duty, ph, pos;
    en   = (w >> 7) & 1;
    duty = w & 127;
    ph   = (w >> 8) & 3;
    pos  = (c - ph * 32 + PER) % PER;
    return (en == 1) && (pos <= duty);
  endfunction

  function automatic string req_for(int w, bit pending);
    if (pending)             return "R6";
    if (((w >> 7) & 1) == 0) return "R2";
    if ((w & 127) == 127)    return "R4";
    if (((w >> 8) & 3) != 0) return "R5";
    return "R3";
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic set_word(int ch, int w);
    ctrl_words[ch*WW +: WW] = WW'(w);
  endtask

  // Entered and left at a falling edge; drives tick, updates the model, compares.
  task automatic step(bit t);
    int w_in;
    bit e;
    tick = t;
    @(posedge clk);
    if (t) begin
      if (m_cnt == PER - 1) begin
        m_cnt = 0;
        for (int k = 0; k < NCH; k++) m_act[k] = int'(ctrl_words[k*WW +: WW]);
      end else begin
        m_cnt++;
      end
    end
    @(negedge clk);
    for (int k = 0; k < NCH; k++) begin
      w_in = int'(ctrl_words[k*WW +: WW]);
      e = expect_on(m_act[k], m_cnt);
      check(drive[k] == e, req_for(m_act[k], w_in != m_act[k]),
            $sformatf("ch%0d cnt=%0d drive", k, m_cnt), int'(drive[k]), int'(e));
      if (drive[k]) hi_cnt[k]++;
    end
    if (!t) check(drive == prev_drive, "R9", "drive moved without tick",
                  int'(drive), int'(prev_drive));
    prev_drive = drive;
  endtask

  task automatic do_reset(int cycles);
    rst_n = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(drive == '0, "R7", "drive during reset", int'(drive), 0);
    end
    rst_n = 1'b1;
    m_cnt = 0;
    for (int k = 0; k < NCH; k++) m_act[k] = 0;
    prev_drive = '0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int counts_exp [NCH];
    for (int k = 0; k < NCH; k++) m_act[k] = 0;
    @(negedge clk);
    do_reset(4);

    // R8: a distinct word in each slot; R7: nothing drives before the first wrap.
    set_word(0, mkw(0, 1, 8'h1A));
    set_word(1, mkw(0, 1, 8'h00));
    set_word(2, mkw(0, 1, 8'h7F));
    set_word(3, mkw(3, 0, 8'h55));
    set_word(4, mkw(2, 1, 31));
    set_word(5, mkw(1, 1, 16));
    for (int i = 0; i < 20; i++) begin
      step(1'b1);
      check(drive == '0, "R7", "drive before first wrap", int'(drive), 0);
    end
    for (int i = 0; i < 200; i++) step(1'b1);

    // R3 R4 R2 R8: on-time over one full period, per channel.
    counts_exp = '{27, 1, 128, 0, 32, 17};
    for (int k = 0; k < NCH; k++) hi_cnt[k] = 0;
    for (int i = 0; i < PER; i++) step(1'b1);
    for (int k = 0; k < NCH; k++)
      check(hi_cnt[k] == counts_exp[k], "R3 R8",
            $sformatf("ch%0d high ticks per period", k), hi_cnt[k], counts_exp[k]);

    // R5: each phase code with the same duty, one channel per code.
    for (int k = 0; k < 4; k++) set_word(k, mkw(k, 1, 15));
    for (int i = 0; i < 300; i++) step(1'b1);

    // R6 R9 R1: sparse ticks, words changed mid-period and on wraps.
    for (int i = 0; i < 1500; i++) begin
      if (($urandom % 40) == 0 || (m_cnt == PER - 1 && ($urandom % 2) == 0))
        set_word(int'($urandom % NCH), int'($urandom % 1024));
      step(($urandom % 10) < 6);
    end

    // R7: reset in mid-run clears every active word.
    do_reset(3);
    for (int i = 0; i < 60; i++) step(1'b1);
    for (int i = 0; i < 300; i++) step(($urandom % 3) != 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule